// File: doc/BRIEF.md
# Programmable Interrupt Source Router

The router sits between a processor's peripheral event wires and its sixteen prioritized interrupt inputs. Line 0 (highest priority) follows the reset event and line 1 the non-maskable event. Lines 2 and 3 are reserved and always inactive. Each of lines 4 to 15 carries one of seventeen event sources, picked by a 5-bit selector code. Software sets these codes through a small register read/write port. The codes are held in two 32-bit selector registers, six fields per register, with one unused gap bit in each 16-bit half.

Four of the seventeen sources are external pins. Each pin passes through a two-flop synchronizer and an edge detector. A per-pin polarity bit picks the rising or the falling edge. A detected edge becomes a one-cycle pulse, but only while the GPIO logic reports that pin as enabled and configured as an input. A priority encoder reports the lowest-numbered active line and a valid flag, for use by the core's interrupt logic.

Top module: `irq_route_top`

## Requirements
- R1: After reset all sixteen lines are low when the event inputs are low. `irq_line[0]` follows `line0_evt` and `irq_line[1]` follows `line1_evt`, with no register delay. `irq_line[2]` and `irq_line[3]` are always 0.
- R2: After reset the selector codes for lines 4..15 are, in line order: 4, 5, 6, 7, 8, 9, 3, 10, 11, 0, 1, 2. The polarity register reads 0.
- R3: Register map. Address 0 holds the codes for lines 4..9 and address 1 holds those for lines 10..15. Field k (k=0..5) sits at bit 5k+(k/3), so the fields are at [4:0], [9:5], [14:10], [20:16], [25:21] and [30:26]. Address 2 holds pin polarity in bits [3:0]. Bits 15 and 31 of addresses 0 and 1, and bits [31:4] of address 2, ignore writes and read 0. A write with `reg_we` high is visible on `reg_rdata` after the next rising clock edge. Reads are combinational from `reg_addr`.
- R4: Line n (4..15) with code c equals source c, combinationally. Codes 0..3 select `periph_evt[c]`. Codes 8..16 select `periph_evt[c-4]`. Codes 4..7 select the pulse of pin c-4.
- R5: Codes 17..31 hold their line at 0.
- R6: Polarity bit p=0 detects a rising edge on `pin_in[p]` and 1 detects a falling edge. Suppose the pin changes between rising edges k and k+1. Then the pulse is high for exactly one cycle, the one that follows edge k+2. The opposite edge produces no pulse.
- R7: A pin produces no pulse unless `pin_en` for that pin is 1 and `pin_out` for that pin is 0.
- R8: Pins produce no event through codes other than 4..7, and `periph_evt` has no path to lines selected with codes 4..7.
- R9: `irq_valid` is 1 exactly when some line is active. `irq_idx` then gives the lowest-numbered active line.
- R10: Address 3 reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| line0_evt | input | 1 | Reset event for line 0 |
| line1_evt | input | 1 | Non-maskable event for line 1 |
| periph_evt | input | 13 | Non-pin sources: codes 0..3, then codes 8..16 |
| pin_in | input | 4 | Asynchronous external pins |
| pin_en | input | 4 | GPIO enable per pin |
| pin_out | input | 4 | GPIO direction per pin, 1 = output |
| irq_line | output | 16 | Interrupt lines to the core |
| irq_valid | output | 1 | Some line is active |
| irq_idx | output | 4 | Lowest-numbered active line |

## Verification
The checker assumes that the register address and data are stable while they are sampled. It also assumes that the event inputs are settled levels when the clock edge samples them. Pins are the exception: they are treated as asynchronous, so the pulse checks look only at the synchronized copies. The bench changes every input a quarter period after the rising edge and keeps each pin level for at least four cycles. This gives each edge its full two-stage synchronization and its compare stage before the next change. The sweeps cover every line against every one of the 32 codes, all four pins under both polarities, both edges and each gating condition, and all 4096 patterns on the remapped lines.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NLINE        = 16;
  localparam int SEL_W        = 5;
  localparam int REG_W        = 32;
  localparam int NFIELD       = 6;
  localparam int FLD_PER_HALF = 3;
  localparam int NFIXED       = 4;
  localparam int NREMAP       = NLINE - NFIXED;
  localparam int NPIN         = 4;
  localparam int PIN_CODE0    = 4;
  localparam int NCODE        = 17;
  localparam int NPERIPH      = NCODE - NPIN;
  localparam int IDX_W        = $clog2(NLINE);

  typedef logic [SEL_W-1:0] sel_t;

  function automatic int fld_lsb(int k);
    return k * SEL_W + k / FLD_PER_HALF;
  endfunction

  function automatic sel_t dflt_sel(int line);
    case (line)
      4:       return 5'd4;
      5:       return 5'd5;
      6:       return 5'd6;
      7:       return 5'd7;
      8:       return 5'd8;
      9:       return 5'd9;
      10:      return 5'd3;
      11:      return 5'd10;
      12:      return 5'd11;
      13:      return 5'd0;
      14:      return 5'd1;
      15:      return 5'd2;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_route_pkg::*;
#(
  parameter int N_PIN  = NPIN,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_raw,
  input  logic [N_PIN-1:0] pin_pol,
  input  logic [N_PIN-1:0] pin_en,
  input  logic [N_PIN-1:0] pin_out,
  output logic [N_PIN-1:0] pulse
);
  // Per pin: SYNC_N synchronizer stages plus one stage holding the previous level.
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic [SYNC_N:0] sh_q, sh_d;
    logic            cur, prv, rise, fall;

    always_comb begin
      sh_d = {sh_q[SYNC_N-1:0], pin_raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    always_comb begin
      cur      = sh_q[SYNC_N-1];
      prv      = sh_q[SYNC_N];
      rise     = cur & ~prv;
      fall     = ~cur & prv;
      pulse[g] = (pin_pol[g] ? fall : rise) & pin_en[g] & ~pin_out[g];
    end
  end
endmodule

// File: rtl/irq_sel_regs.sv
module irq_sel_regs
  import irq_route_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output logic [NREMAP-1:0][SEL_W-1:0] sel,
  output logic [NPIN-1:0]              pol
);
  localparam logic [1:0] A_LO  = 2'd0;
  localparam logic [1:0] A_HI  = 2'd1;
  localparam logic [1:0] A_POL = 2'd2;

  logic [NREMAP-1:0][SEL_W-1:0] sel_q, sel_d;
  logic [NPIN-1:0]              pol_q, pol_d;
  logic                         wr_lo, wr_hi, wr_pol;
  logic                         unused_gap;

  assign unused_gap = reg_wdata[fld_lsb(FLD_PER_HALF) - 1] ^ reg_wdata[REG_W-1];

  always_comb begin
    wr_lo  = reg_we && (reg_addr == A_LO);
    wr_hi  = reg_we && (reg_addr == A_HI);
    wr_pol = reg_we && (reg_addr == A_POL);
    sel_d  = sel_q;
    pol_d  = pol_q;
    for (int k = 0; k < NFIELD; k++) begin
      if (wr_lo) sel_d[k]          = reg_wdata[fld_lsb(k) +: SEL_W];
      if (wr_hi) sel_d[NFIELD + k] = reg_wdata[fld_lsb(k) +: SEL_W];
    end
    if (wr_pol) pol_d = reg_wdata[NPIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREMAP; k++) sel_q[k] <= dflt_sel(NFIXED + k);
      pol_q <= '0;
    end else begin
      if (wr_lo || wr_hi) sel_q <= sel_d;
      if (wr_pol)         pol_q <= pol_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LO: for (int k = 0; k < NFIELD; k++) reg_rdata[fld_lsb(k) +: SEL_W] = sel_q[k];
      A_HI: for (int k = 0; k < NFIELD; k++) reg_rdata[fld_lsb(k) +: SEL_W] = sel_q[NFIELD + k];
      A_POL: reg_rdata[NPIN-1:0] = pol_q;
      default: reg_rdata = '0;
    endcase
  end

  assign sel = sel_q;
  assign pol = pol_q;
endmodule

// File: rtl/irq_src_mux.sv
module irq_src_mux
  import irq_route_pkg::*;
(
  input  logic [NREMAP-1:0][SEL_W-1:0] sel,
  input  logic [NPERIPH-1:0]           periph_evt,
  input  logic [NPIN-1:0]              pin_pulse,
  output logic [NREMAP-1:0]            remap_line
);
  localparam int NSLOT = 2 ** SEL_W;

  logic [NCODE-1:0] src_vec;
  logic [NSLOT-1:0] src_pad;

  // Code order: non-pin sources below the pin block, the pins, then the rest.
  assign src_vec = {periph_evt[NPERIPH-1:PIN_CODE0], pin_pulse, periph_evt[PIN_CODE0-1:0]};
  // Unused codes land on zero-filled slots.
  assign src_pad = {{(NSLOT - NCODE){1'b0}}, src_vec};

  for (genvar g = 0; g < NREMAP; g++) begin : g_line
    assign remap_line[g] = src_pad[sel[g]];
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_route_pkg::*;
(
  input  logic [NLINE-1:0] lines,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = |lines;
    idx   = '0;
    for (int i = NLINE - 1; i >= 0; i--) begin
      if (lines[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               line0_evt,
  input  logic               line1_evt,
  input  logic [NPERIPH-1:0] periph_evt,
  input  logic [NPIN-1:0]    pin_in,
  input  logic [NPIN-1:0]    pin_en,
  input  logic [NPIN-1:0]    pin_out,
  output logic [NLINE-1:0]   irq_line,
  output logic               irq_valid,
  output logic [IDX_W-1:0]   irq_idx
);
  logic [NREMAP-1:0][SEL_W-1:0] sel;
  logic [NPIN-1:0]              pol;
  logic [NPIN-1:0]              pin_pulse;
  logic [NREMAP-1:0]            remap_line;

  irq_sel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sel(sel), .pol(pol)
  );

  irq_pin_edge #(.N_PIN(NPIN), .SYNC_N(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .pin_pol(pol),
    .pin_en(pin_en), .pin_out(pin_out), .pulse(pin_pulse)
  );

  irq_src_mux u_mux (
    .sel(sel), .periph_evt(periph_evt), .pin_pulse(pin_pulse), .remap_line(remap_line)
  );

  assign irq_line = {remap_line, 2'b00, line1_evt, line0_evt};

  irq_prio_enc u_prio (
    .lines(irq_line), .valid(irq_valid), .idx(irq_idx)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         reg_addr,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               line0_evt,
  input logic               line1_evt,
  input logic [NPIN-1:0]    pin_pulse,
  input logic [NLINE-1:0]   irq_line,
  input logic               irq_valid,
  input logic [IDX_W-1:0]   irq_idx
);
  a_r1_fixed_lines: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line[3:2] == 2'b00 && irq_line[0] == line0_evt && irq_line[1] == line1_evt);

  a_r3_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[1] == 1'b0 |-> !reg_rdata[15] && !reg_rdata[31]);

  a_r10_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd3 |-> reg_rdata == '0);

  a_r6_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pulse != '0 |=> (pin_pulse & $past(pin_pulse)) == '0);

  a_r9_index_is_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_line[irq_idx]);

  a_r9_no_lower_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_line & ((NLINE'(1) << irq_idx) - NLINE'(1))) == '0);

  a_r9_idle_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> irq_line == '0);
endmodule

bind irq_route_top irq_route_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .line0_evt(line0_evt), .line1_evt(line1_evt), .pin_pulse(pin_pulse),
  .irq_line(irq_line), .irq_valid(irq_valid), .irq_idx(irq_idx)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        line0_evt, line1_evt;
  logic [12:0] periph_evt;
  logic [3:0]  pin_in, pin_en, pin_out;
  logic [15:0] irq_line;
  logic        irq_valid;
  logic [3:0]  irq_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [4:0] m_sel [16];
  int dflt [12] = '{4, 5, 6, 7, 8, 9, 3, 10, 11, 0, 1, 2};

  always #(CLK_P/2) clk = ~clk;

  irq_route_top i_irq_route_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line0_evt(line0_evt),
    .line1_evt(line1_evt), .periph_evt(periph_evt), .pin_in(pin_in),
    .pin_en(pin_en), .pin_out(pin_out), .irq_line(irq_line),
    .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] pack(input int half);
    logic [31:0] v = '0;
    for (int k = 0; k < 6; k++)
      v = v | (32'(m_sel[4 + 6*half + k]) << (k*5 + k/3));
    return v;
  endfunction

  task automatic setsel(input int line, input int code);
    m_sel[line] = 5'(code);
    wr(line < 10 ? 2'd0 : 2'd1, pack(line < 10 ? 0 : 1));
  endtask

  function automatic logic exp_line(input int code, input logic [12:0] ev);
    if (code < 4)  return ev[code];
    if (code < 8)  return 1'b0;
    if (code < 17) return ev[code-4];
    return 1'b0;
  endfunction

  initial begin
    #(CLK_P*150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    line0_evt = 0; line1_evt = 0; periph_evt = '0;
    pin_in = '0; pin_en = '0; pin_out = '0;
    for (int i = 0; i < 16; i++) m_sel[i] = '0;
    for (int i = 0; i < 12; i++) m_sel[4+i] = 5'(dflt[i]);
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 / R9 reset state
    chk("R1 reset lines", 32'(irq_line), 32'h0);
    chk("R9 reset valid", 32'(irq_valid), 32'h0);
    // R2 defaults
    rd(2'd0, d); chk("R2 default low", d, pack(0));
    rd(2'd1, d); chk("R2 default high", d, pack(1));
    rd(2'd2, d); chk("R2 default polarity", d, 32'h0);

    // R1 fixed lines
    line0_evt = 1; #1;
    chk("R1 line0", 32'(irq_line), 32'h1); chk("R9 idx line0", 32'(irq_idx), 32'h0);
    line0_evt = 0; line1_evt = 1; #1;
    chk("R1 line1", 32'(irq_line), 32'h2); chk("R9 idx line1", 32'(irq_idx), 32'h1);
    line1_evt = 0;

    // R3 gap bits and field widths
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R3 low all ones", d, 32'h7FFF_7FFF);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R3 high all ones", d, 32'h7FFF_7FFF);
    wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, d); chk("R3 polarity width", d, 32'h0000_000F);
    wr(2'd2, 32'h0);
    wr(2'd0, pack(0)); wr(2'd1, pack(1));
    rd(2'd0, d); chk("R3 low readback", d, pack(0));

    // R10 unused address
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R10 addr3 zero", d, 32'h0);
    rd(2'd0, d); chk("R10 low kept", d, pack(0));
    rd(2'd1, d); chk("R10 high kept", d, pack(1));
    rd(2'd2, d); chk("R10 pol kept", d, 32'h0);

    // R4 / R5 / R8 sweep: every line, every code, walking-one and all-ones sources
    for (int line = 4; line < 16; line++) begin
      for (int code = 0; code < 32; code++) begin
        setsel(line, code);
        for (int p = 0; p < 14; p++) begin
          periph_evt = (p < 13) ? 13'(1 << p) : '1;
          #1;
          if (code >= 17)      chk("R5 unused code", 32'(irq_line[line]), 32'h0);
          else if (code >= 4 && code < 8)
                               chk("R8 pin code isolates periph", 32'(irq_line[line]), 32'h0);
          else                 chk("R4 route", 32'(irq_line[line]), 32'(exp_line(code, periph_evt)));
        end
        periph_evt = '0;
      end
      setsel(line, dflt[line-4]);
    end

    // R6 / R7 pin edges: pin, polarity, edge direction, gating mode
    for (int p = 0; p < 4; p++) begin
      setsel(4, 4 + p);
      for (int pol = 0; pol < 2; pol++) begin
        wr(2'd2, 32'(pol) << p);
        for (int rising = 0; rising < 2; rising++) begin
          for (int gm = 0; gm < 3; gm++) begin
            pin_en  = (gm == 1) ? 4'h0 : 4'hF;
            pin_out = (gm == 2) ? 4'hF : 4'h0;
            pin_in[p] = (rising == 1) ? 1'b0 : 1'b1;
            repeat (4) tick();
            pin_in[p] = ~pin_in[p];
            for (int t = 1; t <= 4; t++) begin
              logic e;
              tick();
              e = (t == 2) && (gm == 0) && ((pol == 0) == (rising == 1));
              if (gm == 0) chk("R6 edge pulse", 32'(irq_line[4]), 32'(e));
              else         chk("R7 gated pin", 32'(irq_line[4]), 32'h0);
            end
          end
        end
      end
    end
    pin_in = '0; pin_en = '0;
    repeat (4) tick();
    wr(2'd2, 32'h0);

    // R9 priority: line 4+j driven by periph_evt[j]
    begin
      int codes [12] = '{0, 1, 2, 3, 8, 9, 10, 11, 12, 13, 14, 15};
      for (int j = 0; j < 12; j++) setsel(4 + j, codes[j]);
    end
    for (int v = 0; v < 4096; v++) begin
      for (int f = 0; f < 4; f++) begin
        logic [15:0] el;
        int ei;
        line0_evt = f[0]; line1_evt = f[1];
        periph_evt = {1'b0, 12'(v)};
        #1;
        el = {12'(v), 2'b00, 2'(f)};
        ei = 0;
        for (int i = 15; i >= 0; i--) if (el[i]) ei = i;
        chk("R9 lines", 32'(irq_line), 32'(el));
        chk("R9 valid", 32'(irq_valid), 32'(el != 0));
        if (el != 0) chk("R9 index", 32'(irq_idx), 32'(ei));
      end
    end
    line0_evt = 0; line1_evt = 0; periph_evt = '0;
    tick();
    finish_run();
  end
endmodule